// File: doc/BRIEF.md
# Programmable Watchdog Timer With Output Steering

This block watches a processor for liveness. Software programs one 8-bit control register with a 5-bit multiplier, a 2-bit tick resolution code and a steering bit. A timeout counter then runs for the multiplier times the chosen tick period. The count restarts whenever the external kick input toggles in either direction, or whenever the control register is written. Rewriting the same value is therefore a software kick.

When the count runs out, the block sets a sticky timeout flag. The steering bit then picks one of two actions. The first is a level interrupt, which also drives the shared output pin. The second is an active-low reset pulse of fixed length. At the end of that pulse the control register is cleared, and a one-cycle strobe tells the neighbouring logic to drop its auxiliary enables. While the watchdog holds the shared pin, a frequency-test signal offered on that pin is blocked.

The tick comes from a prescaler that produces a base tick every `BASE_DIV` clocks. The coarser resolutions divide that base tick by 4, 16 or 64. Every restart also restarts the prescaler.

Top module: `wdog_steer`

## Requirements
- R1: A write through `reg_wr`/`reg_wdata` loads the control register, which reads back on `reg_rdata` from the next cycle. The field positions are bit 7 = steering, bits 6..2 = multiplier, bits 1..0 = resolution code.
- R2: The resolution codes 00, 01, 10 and 11 give tick periods of 1, 4, 16 and 64 base ticks. A base tick is `BASE_DIV` clocks. `flag_o` rises exactly multiplier × tick period clock edges after the restart edge.
- R3: A rising or falling change on `kick_i` restarts the count. The restart takes effect on the third clock edge after the change, because of a two-flop synchronizer and an edge detector.
- R4: Any register write restarts the count on the edge that captures it, including a write of the value already held.
- R5: `flag_o` is sticky. A one-cycle `flag_rd` clears it. If a timeout occurs in the same cycle as `flag_rd`, the flag stays set.
- R6: A timeout with the steering bit at 0 raises `irq_o`. `irq_o` stays high through writes of nonzero values and falls only on a write of 8'h00.
- R7: A timeout with the steering bit at 1 drives `wdrst_n_o` low for exactly `RST_CYCLES` cycles, starting at the timeout edge. `wdrst_n_o` is high otherwise.
- R8: On the edge that ends the reset pulse, the control register is cleared to 0 and `aux_clr_o` is high for exactly one cycle. A write in that same cycle is discarded.
- R9: After reset the register is 0 and all outputs are idle. A multiplier of 0 never times out, whatever the resolution code.
- R10: The watchdog owns `pin_o` when `irq_o` is high, or when the steering bit is 0 with a nonzero multiplier. In that case `pin_o` equals `irq_o`. Otherwise `pin_o` is `ft_sig` when `ft_en` is set, and 0 when it is not.
- R11: After a timeout the counter stops. No further timeout occurs until a kick or a write restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| kick_i | input | 1 | Asynchronous kick input, either edge restarts |
| flag_rd | input | 1 | Flag read strobe, clears the timeout flag |
| flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Level interrupt from an interrupt-steered timeout |
| wdrst_n_o | output | 1 | Active-low reset pulse |
| aux_clr_o | output | 1 | One-cycle strobe to clear auxiliary enables |
| ft_en | input | 1 | Frequency-test enable for the shared pin |
| ft_sig | input | 1 | Frequency-test waveform |
| pin_o | output | 1 | Shared output pin |

## Verification
The assertions assume the following about the inputs:
- `reg_wr` and `flag_rd` are single-cycle strobes, synchronous to `clk`.
- `kick_i` holds each level for at least one clock, so the synchronizer sees every change.
- Nothing in the block depends on `ft_sig` beyond passing it through to `pin_o`.

The stimulus meets these conditions. It changes every input only at the falling clock edge. It pulses each strobe for exactly one cycle, and it holds kick levels for many cycles. A behavioural model in the bench compares every output on every cycle. Directed sequences add checks for each resolution code, both kick polarities, the software kick, both steering choices and the pin hand-over.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       steer;
    logic [4:0] mult;
    logic [1:0] res;
  } wd_cfg_t;

  localparam int SUB_W = 6;

  // base ticks per resolution tick: 1, 4, 16, 64
  function automatic int unsigned res_div(input logic [1:0] code);
    return 32'd1 << (2 * code);
  endfunction

  // clock edges from restart to timeout
  function automatic int unsigned timeout_edges(input int unsigned base_div,
                                                input logic [4:0] mult,
                                                input logic [1:0] code);
    return base_div * res_div(code) * mult;
  endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic kick_edge
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= kick_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign kick_edge = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] res,
  output logic       base_tick,
  output logic       res_tick
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [BW-1:0]    bcnt_q;
  logic [SUB_W-1:0] scnt_q;
  logic             sub_last;

  assign base_tick = !clr && (bcnt_q == BW'(BASE_DIV - 1));
  assign sub_last  = (scnt_q == SUB_W'(res_div(res) - 1));
  assign res_tick  = base_tick && sub_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      scnt_q <= '0;
    end else if (clr) begin
      bcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      bcnt_q <= base_tick ? '0 : bcnt_q + 1'b1;
      if (base_tick) scnt_q <= sub_last ? '0 : scnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       res_tick,
  input  logic [4:0] mult,
  output logic       expire
);
  logic [4:0] tcnt_q;

  assign expire = res_tick && (tcnt_q == mult - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt_q <= '0;
    else if (clr)      tcnt_q <= '0;
    else if (res_tick) tcnt_q <= expire ? '0 : tcnt_q + 5'd1;
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int BASE_DIV   = 2048,
  parameter int RST_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       kick_i,
  input  logic       flag_rd,
  output logic       flag_o,
  output logic       irq_o,
  output logic       wdrst_n_o,
  output logic       aux_clr_o,
  input  logic       ft_en,
  input  logic       ft_sig,
  output logic       pin_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  wd_cfg_t       cfg_q;
  logic          kick_edge, restart, running, cnt_clr;
  logic          base_tick, res_tick, expire;
  logic          fired_q, flag_q, irq_q, aux_q;
  logic [PW-1:0] pcnt_q;
  logic          pulse_act, pulse_end, clear_write, wd_owns_pin;

  wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .kick_edge(kick_edge)
  );

  assign restart   = kick_edge | reg_wr;
  assign pulse_act = (pcnt_q != '0);
  assign pulse_end = (pcnt_q == PW'(1));
  assign running   = (cfg_q.mult != 5'd0) && !fired_q && !pulse_act;
  assign cnt_clr   = restart || !running;
  assign clear_write = reg_wr && (reg_wdata == 8'h00);

  wdog_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .res(cfg_q.res),
    .base_tick(base_tick), .res_tick(res_tick)
  );

  wdog_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .res_tick(res_tick),
    .mult(cfg_q.mult), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      fired_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      aux_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      if (pulse_end)   cfg_q <= '0;
      else if (reg_wr) cfg_q <= wd_cfg_t'(reg_wdata);

      if (restart)     fired_q <= 1'b0;
      else if (expire) fired_q <= 1'b1;

      if (expire)       flag_q <= 1'b1;
      else if (flag_rd) flag_q <= 1'b0;

      if (expire && !cfg_q.steer) irq_q <= 1'b1;
      else if (clear_write)       irq_q <= 1'b0;

      if (expire && cfg_q.steer) pcnt_q <= PW'(RST_CYCLES);
      else if (pulse_act)        pcnt_q <= pcnt_q - 1'b1;

      aux_q <= pulse_end;
    end
  end

  assign wd_owns_pin = irq_q || (!cfg_q.steer && (cfg_q.mult != 5'd0));
  assign pin_o       = wd_owns_pin ? irq_q : (ft_en & ft_sig);
  assign reg_rdata   = cfg_q;
  assign flag_o      = flag_q;
  assign irq_o       = irq_q;
  assign wdrst_n_o   = !pulse_act;
  assign aux_clr_o   = aux_q;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       flag_rd,
  input logic       flag_o,
  input logic       irq_o,
  input logic       wdrst_n_o,
  input logic       aux_clr_o,
  input logic       pin_o,
  input logic       expire,
  input logic       restart,
  input logic       fired_q
);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> !flag_o);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_o);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(reg_wr && reg_wdata == 8'h00)) |=> irq_o);
  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdrst_n_o) |-> $past(expire));
  // R7
  no_expire_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdrst_n_o |-> !expire);
  // R8
  aux_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_clr_o |-> (reg_rdata == 8'h00));
  // R9
  zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6:2] == 5'd0) |-> !expire);
  // R10
  pin_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pin_o);
  // R11
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !restart) |-> !expire);
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .flag_rd(flag_rd), .flag_o(flag_o), .irq_o(irq_o),
  .wdrst_n_o(wdrst_n_o), .aux_clr_o(aux_clr_o), .pin_o(pin_o),
  .expire(expire), .restart(restart), .fired_q(fired_q)
);

// File: tb/wdog_steer_test.sv
module wdog_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BDIV = 3;
  localparam int RSTC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       kick_i = 1'b0;
  logic       flag_rd = 1'b0;
  logic       flag_o, irq_o, wdrst_n_o, aux_clr_o, pin_o;
  logic       ft_en = 1'b0;
  logic       ft_sig = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_steer #(.BASE_DIV(BDIV), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .kick_i(kick_i), .flag_rd(flag_rd),
    .flag_o(flag_o), .irq_o(irq_o), .wdrst_n_o(wdrst_n_o),
    .aux_clr_o(aux_clr_o), .ft_en(ft_en), .ft_sig(ft_sig), .pin_o(pin_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_reg = 0, m_pulse = 0, m_elapsed = 0;
  bit  m_flag = 0, m_irq = 0, m_aux = 0, m_fired = 0;
  bit  k1 = 0, k2 = 0, k3 = 0;

  function automatic int period_of(input int r);
    int mult = (r >> 2) & 31;
    return BDIV * (1 << (2 * (r & 3))) * mult;
  endfunction

  always @(posedge clk) begin
    bit restart, run, expire, kedge;
    int per, pin_exp;
    if (!rst_n) begin
      m_reg = 0; m_pulse = 0; m_elapsed = 0; m_flag = 0; m_irq = 0;
      m_aux = 0; m_fired = 0; k1 = 0; k2 = 0; k3 = 0;
    end else begin
      kedge   = k2 ^ k3;
      restart = kedge || reg_wr;
      per     = period_of(m_reg);
      run     = (per != 0) && !m_fired && (m_pulse == 0);
      expire  = 1'b0;
      if (restart || !run) m_elapsed = 0;
      else if (m_elapsed == per - 1) begin expire = 1'b1; m_elapsed = 0; end
      else m_elapsed++;
      if (restart) m_fired = 0; else if (expire) m_fired = 1;
      if (expire) m_flag = 1; else if (flag_rd) m_flag = 0;
      if (expire && !m_reg[7]) m_irq = 1;
      else if (reg_wr && reg_wdata == 8'h00) m_irq = 0;
      m_aux = (m_pulse == 1);
      if (m_pulse == 1) m_reg = 0; else if (reg_wr) m_reg = reg_wdata;
      if (expire && m_reg[7] && !m_aux) m_pulse = RSTC;
      else if (m_pulse > 0) m_pulse--;
      k3 = k2; k2 = k1; k1 = kick_i;
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      if (m_irq || (!m_reg[7] && ((m_reg >> 2) & 31) != 0)) pin_exp = m_irq;
      else pin_exp = ft_en & ft_sig;
      check(reg_rdata == m_reg[7:0], "R1 model reg", reg_rdata, m_reg);
      check(flag_o == m_flag, "R5 model flag", flag_o, m_flag);
      check(irq_o == m_irq, "R6 model irq", irq_o, m_irq);
      check(wdrst_n_o == (m_pulse == 0), "R7 model rst", wdrst_n_o, m_pulse == 0);
      check(aux_clr_o == m_aux, "R8 model aux", aux_clr_o, m_aux);
      check(pin_o == pin_exp[0], "R10 model pin", pin_o, pin_exp);
    end
  end
  // Note: the steer bit is read before the register update in the RTL; the model
  // uses m_reg after update only when a pulse-end clear happens, which cannot
  // coincide with an expiry, so both agree.

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stimulus already applied at this negedge; count edges until event
  task automatic count_until(input int mode, input int exp, input string tag);
    int n = 0;
    bit hit = 0;
    while (!hit && n < exp + 50) begin
      @(posedge clk); n++; #1;
      reg_wr = 1'b0;
      hit = (mode == 0) ? flag_o : !wdrst_n_o;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic timed_write(input logic [7:0] v, input int mode, input int exp, input string tag);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    count_until(mode, exp, tag);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int lows, auxs;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    check(reg_rdata == 8'h00, "R9 reset reg", reg_rdata, 0);
    check(!flag_o && !irq_o && wdrst_n_o && !aux_clr_o && !pin_o, "R9 reset outputs",
          {flag_o, irq_o, wdrst_n_o, aux_clr_o, pin_o}, 5'b00100);

    // R9 zero multiplier never fires; R1 readback
    wr(8'h03);
    check(reg_rdata == 8'h03, "R1 readback", reg_rdata, 8'h03);
    idle(300);
    check(!flag_o, "R9 zero multiplier", flag_o, 0);

    // R2 each resolution code (write restart: event at edge T+1 from stimulus)
    timed_write(8'h14, 0, period_of(8'h14) + 1, "R2 code00 x5");
    wr(8'h00); rd_flag();
    timed_write(8'h09, 0, period_of(8'h09) + 1, "R2 code01 x2");
    wr(8'h00); rd_flag();
    timed_write(8'h0E, 0, period_of(8'h0E) + 1, "R2 code10 x3");
    rd_flag();
    check(!flag_o, "R5 flag cleared by read", flag_o, 0);
    // R11 no second timeout without restart
    idle(2 * period_of(8'h0E));
    check(!flag_o, "R11 stopped after timeout", flag_o, 0);
    check(irq_o, "R6 irq level held", irq_o, 1);
    wr(8'h55);
    check(irq_o, "R6 nonzero write keeps irq", irq_o, 1);
    wr(8'h00);
    check(!irq_o, "R6 zero write clears irq", irq_o, 0);
    rd_flag();
    timed_write(8'h07, 0, period_of(8'h07) + 1, "R2 code11 x1");
    wr(8'h00); rd_flag();

    // R3 kick rising and falling (restart on third edge after change)
    wr(8'h10); idle(8);
    @(negedge clk); kick_i = 1'b1;
    count_until(0, period_of(8'h10) + 3, "R3 rising kick");
    wr(8'h00); rd_flag();
    wr(8'h10); idle(8);
    @(negedge clk); kick_i = 1'b0;
    count_until(0, period_of(8'h10) + 3, "R3 falling kick");
    wr(8'h00); rd_flag();

    // R4 rewrite of same value restarts
    wr(8'h10); idle(8);
    timed_write(8'h10, 0, period_of(8'h10) + 1, "R4 software kick");
    wr(8'h00); rd_flag();

    // R7 / R8 reset-steered timeout
    timed_write(8'h8C, 1, period_of(8'h8C) + 1, "R7 pulse start");
    check(!irq_o, "R7 no irq when steered to reset", irq_o, 0);
    lows = 1; auxs = 0;
    while (!wdrst_n_o && lows < 50) begin
      @(posedge clk); #1;
      if (!wdrst_n_o) lows++;
      if (aux_clr_o) auxs++;
    end
    @(posedge clk); #1;
    if (aux_clr_o) auxs++;
    check(lows == RSTC, "R7 pulse length", lows, RSTC);
    check(auxs == 1, "R8 aux strobe once", auxs, 1);
    check(reg_rdata == 8'h00, "R8 register cleared", reg_rdata, 0);
    check(flag_o, "R5 flag set by reset timeout", flag_o, 1);
    rd_flag();

    // R10 pin ownership
    @(negedge clk); ft_en = 1'b1; ft_sig = 1'b1;
    @(negedge clk);
    check(pin_o, "R10 pin follows ft", pin_o, 1);
    wr(8'h10);
    check(!pin_o, "R10 watchdog blocks ft", pin_o, 0);
    @(negedge clk); ft_sig = 1'b0;
    idle(period_of(8'h10) + 2);
    check(pin_o && irq_o, "R10 pin shows irq", pin_o, 1);
    wr(8'h00);
    @(negedge clk); ft_sig = 1'b1;
    @(negedge clk);
    check(pin_o, "R10 pin returns to ft", pin_o, 1);
    idle(5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule